// File: doc/BRIEF.md
# Mode-Switch Branch Decoder

This decode-stage unit watches every 32-bit instruction word of a core that can execute in three instruction-set modes: the standard 64-bit compressed-capable set, a co-execution mode and a native mode. Unsigned loads that write x0 normally have no architectural effect. This unit reinterprets them as branches that also change the execution mode. The width of the load selects the destination mode. The base register value plus a sign-extended displacement gives the target address. Every such branch requests a pipeline flush, so that fetch restarts in the new mode.

When the feature-enable input is low, the same encodings pass through untouched, as the no-ops they are on a core without the extension. While the core runs in native mode, the displacement field is narrower. All outputs are registered once, and reset returns the block to the standard mode with no flush pending.

Top module: `mode_branch_decoder`

## Requirements
- R1: An instruction with opcode bits [6:0] = 0000011, rd bits [11:7] = 0 and funct3 bits [14:12] = 100 (byte, unsigned) is a taken switch to mode 00 (standard set) when enabled.
- R2: The same form with funct3 = 110 (word, unsigned) is a taken switch to mode 01 (co-execution).
- R3: The same form with funct3 = 101 (halfword, unsigned) is a taken switch to mode 10 (native).
- R4: Any other opcode, any nonzero rd, or any other funct3 value is not taken and raises no flush.
- R5: Outside native mode, the target is base_i plus instr_i[31:20] sign-extended from bit 31, computed modulo 2^64.
- R6: When cur_mode_i = 10 (native), the displacement is instr_i[29:20] sign-extended from bit 29, and bits [31:30] have no effect.
- R7: Bit 0 of the target output is always cleared.
- R8: Every taken switch asserts flush, including a switch to the mode that is already current.
- R9: With switch_en_i low, a matching encoding is a no-op: not taken, no flush, target 0, and next_mode_o equal to the current mode.
- R10: When not taken, next_mode_o repeats cur_mode_i, except that the reserved code 11 is reported as 00, and target_o is 0.
- R11: Outputs appear one clock after the inputs. Reset (rst_n low) gives taken 0, flush 0, next mode 00 and target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word under decode |
| base_i | input | XLEN | Value of the base register named by the instruction |
| cur_mode_i | input | 2 | Current execution mode (00 standard, 01 co-execution, 10 native) |
| switch_en_i | input | 1 | Enables mode-switch branches |
| taken_o | output | 1 | Registered: a mode-switch branch was decoded |
| target_o | output | XLEN | Registered branch target, bit 0 cleared |
| next_mode_o | output | 2 | Registered mode that follows this instruction |
| flush_o | output | 1 | Registered pipeline flush request |

## Verification
The bench gives each of the three load widths an encoding that matches exactly, and checks that each one selects its own mode. Near-miss words differ from a match only in rd, funct3 or opcode, which shows that every field takes part in the match. Displacements that are positive, negative, at the upper bound and wrapping are tried under both the standard and the native current mode. In particular, fields whose bit 9 or bits [31:30] are set give different targets under the two widths, so a wrong width selection shows up at the target output. A disabled enable, a reserved current mode, a switch to the mode already current and a reset during activity each test one of the fallback and flush rules.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

   typedef enum logic [1:0] {
      MODE_STD    = 2'b00,
      MODE_COEX   = 2'b01,
      MODE_NATIVE = 2'b10,
      MODE_RSVD   = 2'b11
   } exec_mode_e;

   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [2:0] F3_BYTE_U  = 3'b100;
   localparam logic [2:0] F3_HALF_U  = 3'b101;
   localparam logic [2:0] F3_WORD_U  = 3'b110;
   localparam int         IMM_FIELD_W = 12;

   typedef struct packed {
      logic       hit;
      exec_mode_e dest;
   } switch_dec_t;

endpackage

// File: rtl/mbd_classify.sv
module mbd_classify
   import mbd_pkg::*;
(
   input  logic [6:0]  opcode_i,
   input  logic [4:0]  rd_i,
   input  logic [2:0]  funct3_i,
   input  logic        enable_i,
   output switch_dec_t dec_o
);

   logic form_ok;

   // Only loads that discard their result into x0 are candidates.
   assign form_ok = enable_i && (opcode_i == OPC_LOAD) && (rd_i == 5'd0);

   always_comb begin
      dec_o.hit  = 1'b0;
      dec_o.dest = MODE_STD;
      if (form_ok) begin
         unique case (funct3_i)
            F3_BYTE_U: begin dec_o.hit = 1'b1; dec_o.dest = MODE_STD;    end
            F3_WORD_U: begin dec_o.hit = 1'b1; dec_o.dest = MODE_COEX;   end
            F3_HALF_U: begin dec_o.hit = 1'b1; dec_o.dest = MODE_NATIVE; end
            default:   begin dec_o.hit = 1'b0; dec_o.dest = MODE_STD;    end
         endcase
      end
   end

endmodule

// File: rtl/mbd_disp_ext.sv
module mbd_disp_ext
   import mbd_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int DISP_STD_W = 12,
   parameter int DISP_NAT_W = 10
) (
   input  logic [IMM_FIELD_W-1:0] field_i,
   input  logic                   native_i,
   output logic [XLEN-1:0]        disp_o
);

   localparam int STD_PAD = XLEN - DISP_STD_W;
   localparam int NAT_PAD = XLEN - DISP_NAT_W;

   logic [XLEN-1:0] disp_std;

   assign disp_std = {{STD_PAD{field_i[DISP_STD_W-1]}}, field_i[DISP_STD_W-1:0]};

   generate
      if (DISP_NAT_W == DISP_STD_W) begin : g_one_width
         logic unused_native;
         assign unused_native = native_i;
         assign disp_o        = disp_std;
      end else begin : g_two_widths
         logic [XLEN-1:0] disp_nat;
         assign disp_nat = {{NAT_PAD{field_i[DISP_NAT_W-1]}}, field_i[DISP_NAT_W-1:0]};
         assign disp_o   = native_i ? disp_nat : disp_std;
      end
   endgenerate

endmodule

// File: rtl/mbd_target.sv
module mbd_target #(
   parameter int XLEN      = 64,
   parameter bit CLEAR_LSB = 1'b1
) (
   input  logic [XLEN-1:0] base_i,
   input  logic [XLEN-1:0] disp_i,
   output logic [XLEN-1:0] target_o
);

   logic [XLEN-1:0] sum;

   assign sum = base_i + disp_i;

   generate
      if (CLEAR_LSB) begin : g_align
         assign target_o = {sum[XLEN-1:1], 1'b0};
      end else begin : g_raw
         assign target_o = sum;
      end
   endgenerate

endmodule

// File: rtl/mode_branch_decoder.sv
module mode_branch_decoder
   import mbd_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int DISP_STD_W = 12,
   parameter int DISP_NAT_W = 10,
   parameter bit CLEAR_LSB  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     instr_i,
   input  logic [XLEN-1:0] base_i,
   input  logic [1:0]      cur_mode_i,
   input  logic            switch_en_i,
   output logic            taken_o,
   output logic [XLEN-1:0] target_o,
   output logic [1:0]      next_mode_o,
   output logic            flush_o
);

   // Elaboration-time parameter checks
   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("mode_branch_decoder: XLEN must be at least 32");
      end
      if (DISP_STD_W > IMM_FIELD_W || DISP_STD_W < 2) begin : g_bad_std
         $error("mode_branch_decoder: DISP_STD_W must lie in 2..12");
      end
      if (DISP_NAT_W > DISP_STD_W || DISP_NAT_W < 2) begin : g_bad_nat
         $error("mode_branch_decoder: DISP_NAT_W must lie in 2..DISP_STD_W");
      end
   endgenerate

   exec_mode_e      cur_mode;
   switch_dec_t     dec;
   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] tgt;
   logic            unused_rs1;

   logic            nxt_taken;
   logic [XLEN-1:0] nxt_target;
   exec_mode_e      nxt_mode;

   assign cur_mode   = exec_mode_e'(cur_mode_i);
   assign unused_rs1 = ^instr_i[19:15];

   mbd_classify u_classify (
      .opcode_i (instr_i[6:0]),
      .rd_i     (instr_i[11:7]),
      .funct3_i (instr_i[14:12]),
      .enable_i (switch_en_i),
      .dec_o    (dec)
   );

   mbd_disp_ext #(
      .XLEN       (XLEN),
      .DISP_STD_W (DISP_STD_W),
      .DISP_NAT_W (DISP_NAT_W)
   ) u_disp (
      .field_i  (instr_i[31:20]),
      .native_i (cur_mode == MODE_NATIVE),
      .disp_o   (disp)
   );

   mbd_target #(
      .XLEN      (XLEN),
      .CLEAR_LSB (CLEAR_LSB)
   ) u_target (
      .base_i   (base_i),
      .disp_i   (disp),
      .target_o (tgt)
   );

   always_comb begin
      nxt_taken  = dec.hit;
      nxt_target = '0;
      nxt_mode   = (cur_mode == MODE_RSVD) ? MODE_STD : cur_mode;
      if (dec.hit) begin
         nxt_target = tgt;
         nxt_mode   = dec.dest;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_o     <= 1'b0;
         flush_o     <= 1'b0;
         target_o    <= '0;
         next_mode_o <= MODE_STD;
      end else begin
         taken_o     <= nxt_taken;
         flush_o     <= nxt_taken;
         target_o    <= nxt_target;
         next_mode_o <= nxt_mode;
      end
   end

   // Assertions
   assert_flush_on_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o |-> flush_o);

   assert_no_stray_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> taken_o);

   assert_disabled_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !switch_en_i |=> (!taken_o && !flush_o));

   assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      next_mode_o != MODE_RSVD);

   assert_idle_target_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !taken_o |-> (target_o == '0));

   assert_nonload_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[6:0] != OPC_LOAD) |=> !taken_o);

   generate
      if (CLEAR_LSB) begin : g_lsb_check
         assert_target_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
            target_o[0] == 1'b0);
      end
   endgenerate

endmodule

// File: tb/mode_branch_decoder_tb.sv
module mode_branch_decoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 64;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [31:0]     instr;
   logic [XLEN-1:0] base;
   logic [1:0]      cur_mode;
   logic            sw_en;
   logic            taken;
   logic [XLEN-1:0] target;
   logic [1:0]      next_mode;
   logic            flush;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mode_branch_decoder #(.XLEN(XLEN)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_i     (instr),
      .base_i      (base),
      .cur_mode_i  (cur_mode),
      .switch_en_i (sw_en),
      .taken_o     (taken),
      .target_o    (target),
      .next_mode_o (next_mode),
      .flush_o     (flush)
   );

   function automatic logic [31:0] enc(input logic [11:0] imm, input logic [2:0] f3,
                                       input logic [4:0] rd, input logic [6:0] opc);
      return {imm, 5'd3, f3, rd, opc};
   endfunction

   task automatic check(input string req, input logic e_taken, input logic [XLEN-1:0] e_tgt,
                        input logic [1:0] e_mode, input logic e_flush);
      n_checks++;
      if (taken !== e_taken || target !== e_tgt || next_mode !== e_mode || flush !== e_flush) begin
         n_fail++;
         $display("FAIL %s: actual taken=%0b target=%h mode=%b flush=%0b expected taken=%0b target=%h mode=%b flush=%0b",
                  req, taken, target, next_mode, flush, e_taken, e_tgt, e_mode, e_flush);
      end
   endtask

   // Drive on a falling edge, capture on the next rising edge, check on the following falling edge.
   task automatic apply(input logic [31:0] i, input logic [XLEN-1:0] b,
                        input logic [1:0] m, input logic en);
      @(negedge clk);
      instr = i; base = b; cur_mode = m; sw_en = en;
      @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; instr = '0; base = '0; cur_mode = 2'b01; sw_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 reset state", 1'b0, '0, 2'b00, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_three_widths;
      apply(enc(12'h010, 3'b100, 5'd0, 7'b0000011), 64'h1000, 2'b01, 1'b1);
      check("R1 byte-unsigned to std", 1'b1, 64'h1010, 2'b00, 1'b1);
      apply(enc(12'hFFC, 3'b110, 5'd0, 7'b0000011), 64'h2000, 2'b00, 1'b1);
      check("R2 word-unsigned to coex, R5 negative disp", 1'b1, 64'h1FFC, 2'b01, 1'b1);
      apply(enc(12'h7FF, 3'b101, 5'd0, 7'b0000011), 64'h0, 2'b00, 1'b1);
      check("R3 half-unsigned to native, R7 lsb cleared", 1'b1, 64'h7FE, 2'b10, 1'b1);
   endtask

   task automatic t_disp_widths;
      apply(enc(12'h200, 3'b100, 5'd0, 7'b0000011), 64'h1000, 2'b00, 1'b1);
      check("R5 12-bit disp in std mode", 1'b1, 64'h1200, 2'b00, 1'b1);
      apply(enc(12'h200, 3'b100, 5'd0, 7'b0000011), 64'h1000, 2'b10, 1'b1);
      check("R6 10-bit disp in native mode", 1'b1, 64'h0E00, 2'b00, 1'b1);
      apply(enc(12'hC05, 3'b110, 5'd0, 7'b0000011), 64'h100, 2'b10, 1'b1);
      check("R6 bits 31:30 ignored in native", 1'b1, 64'h104, 2'b01, 1'b1);
      apply(enc(12'hFFE, 3'b100, 5'd0, 7'b0000011), 64'h0, 2'b01, 1'b1);
      check("R5 wrap below zero", 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 2'b00, 1'b1);
   endtask

   task automatic t_same_mode;
      apply(enc(12'h020, 3'b110, 5'd0, 7'b0000011), 64'h3000, 2'b01, 1'b1);
      check("R8 same-mode switch flushes", 1'b1, 64'h3020, 2'b01, 1'b1);
   endtask

   task automatic t_near_miss;
      apply(enc(12'h010, 3'b100, 5'd5, 7'b0000011), 64'h1000, 2'b10, 1'b1);
      check("R4 nonzero rd", 1'b0, '0, 2'b10, 1'b0);
      apply(enc(12'h010, 3'b010, 5'd0, 7'b0000011), 64'h1000, 2'b01, 1'b1);
      check("R4 signed word load", 1'b0, '0, 2'b01, 1'b0);
      apply(enc(12'h010, 3'b011, 5'd0, 7'b0000011), 64'h1000, 2'b00, 1'b1);
      check("R4 doubleword load", 1'b0, '0, 2'b00, 1'b0);
      apply(enc(12'h010, 3'b100, 5'd0, 7'b0010011), 64'h1000, 2'b01, 1'b1);
      check("R4 non-load opcode", 1'b0, '0, 2'b01, 1'b0);
   endtask

   task automatic t_disabled;
      apply(enc(12'h010, 3'b101, 5'd0, 7'b0000011), 64'h1000, 2'b01, 1'b0);
      check("R9 disabled half-unsigned is no-op", 1'b0, '0, 2'b01, 1'b0);
      apply(enc(12'h010, 3'b100, 5'd0, 7'b0000011), 64'h1000, 2'b10, 1'b0);
      check("R9 disabled byte-unsigned is no-op", 1'b0, '0, 2'b10, 1'b0);
   endtask

   task automatic t_reserved_mode;
      apply(32'h0000_0013, 64'h1000, 2'b11, 1'b1);
      check("R10 reserved mode reported as std", 1'b0, '0, 2'b00, 1'b0);
   endtask

   task automatic t_latency_and_reset;
      @(negedge clk);
      instr = enc(12'h040, 3'b101, 5'd0, 7'b0000011); base = 64'h5000; cur_mode = 2'b00; sw_en = 1'b1;
      @(posedge clk); #1;
      check("R11 output after one edge", 1'b1, 64'h5040, 2'b10, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R11 reset clears outputs", 1'b0, '0, 2'b00, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_three_widths();
      t_disp_widths();
      t_same_mode();
      t_near_miss();
      t_disabled();
      t_reserved_mode();
      t_latency_and_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual run still active expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule